// File: doc/BRIEF.md
# Linked-List Summation Engine

This block walks a singly linked list held in memory and adds up the data values of all its nodes. A node takes two consecutive words: the word at the node's own address holds the address of the next node, and the word one address above it holds the node's value. A start pulse sends the walk to the node at address zero. The walk ends when a fetched next-node address is zero.

The block reads memory through one read-only port whose data returns one cycle after the address is presented. The datapath has a next-node register and an accumulator. Each has its own select mux and its own load enable. An address mux picks either the node address or the node address plus one. A zero detect on the next-node register is fed back to the controller, which decides whether to loop. When the walk ends, the accumulated total is copied to the result output and a completion flag rises. Both hold until the next accepted start.

Top module: `list_sum_engine`

## Requirements
- R1: While reset is high at a clock edge, the engine returns to idle and clears `finished`, `total`, `mem_rd`, the next-node register and the accumulator.
- R2: A `go` seen high at a clock edge while idle clears the next-node register and the accumulator, and drops `finished`. In the following cycle the engine requests address 1, which is the value of the node at address 0.
- R3: For each visited node at address p, the word at address p+1 is added into the accumulator, and the sum wraps modulo 2^16.
- R4: After a node's value is added, the word at address p is loaded as the next node address. The walk continues to that node when the address is nonzero, and ends when it is zero.
- R5: The node at address 0 is always summed, even when its own next address is 0 (a single-node list).
- R6: For a list of N nodes, `finished` is low during the walk and rises in the cycle after the 5N-th clock edge that follows the accepting edge. At that point `total` equals the wrapped sum.
- R7: Once high, `finished` and `total` hold unchanged until the next accepted `go`.
- R8: A `go` that arrives while a walk is in progress has no effect on the address sequence, the timing or the result.
- R9: Each node costs exactly two single-cycle read requests (`mem_rd` high for one cycle each). The first goes to address p+1 and the second, two cycles later, goes to address p. Each is followed by one cycle in which the returned word is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start pulse, honoured only when idle |
| mem_addr | output | 8 | Memory read address |
| mem_rd | output | 1 | Read request, one cycle wide |
| mem_rdata | input | 16 | Read data, valid the cycle after the request |
| total | output | 16 | Sum of the last completed walk |
| finished | output | 1 | High when a walk has completed, until the next start |

## Verification
The single-node list at address zero targets a design that tests for the terminator before summing. Such a design would report zero instead of the node's value. The scattered four-node chain catches swapped value and pointer addresses, which would follow garbage links or add pointers. A chain whose values overflow sixteen bits exposes a design that saturates or widens the sum, which would give the wrong total. A start pulse in the middle of a walk would restart the walk and disturb the per-cycle address sequence and the completion cycle, both of which the bench compares on every clock.

// File: rtl/list_sum_engine.sv
module list_sum_engine #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] total,
  output logic          finished
);
  typedef enum logic [2:0] {S_IDLE, S_VREQ, S_VGET, S_PREQ, S_PGET, S_TEST} st_t;
  st_t st, st_nx;

  logic [AW-1:0] nxt;
  logic [DW-1:0] acc;
  logic ld_nxt, ld_acc, sel_nxt, sel_acc, sel_addr;
  logic nxt_zero, is_idle, is_test;

  assign nxt_zero = (nxt == '0);
  assign is_idle  = (st == S_IDLE);
  assign is_test  = (st == S_TEST);
  assign mem_addr = sel_addr ? nxt : AW'(nxt + 1'b1);

  always_comb begin
    st_nx    = st;
    ld_nxt   = 1'b0;
    ld_acc   = 1'b0;
    sel_nxt  = 1'b0;
    sel_acc  = 1'b0;
    sel_addr = 1'b0;
    mem_rd   = 1'b0;
    case (st)
      S_IDLE: if (go) begin
        ld_nxt = 1'b1;
        ld_acc = 1'b1;
        st_nx  = S_VREQ;
      end
      S_VREQ: begin
        mem_rd = 1'b1;
        st_nx  = S_VGET;
      end
      S_VGET: begin
        ld_acc  = 1'b1;
        sel_acc = 1'b1;
        st_nx   = S_PREQ;
      end
      S_PREQ: begin
        mem_rd   = 1'b1;
        sel_addr = 1'b1;
        st_nx    = S_PGET;
      end
      S_PGET: begin
        ld_nxt  = 1'b1;
        sel_nxt = 1'b1;
        st_nx   = S_TEST;
      end
      S_TEST: st_nx = nxt_zero ? S_IDLE : S_VREQ;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      nxt      <= '0;
      acc      <= '0;
      total    <= '0;
      finished <= 1'b0;
    end else begin
      st <= st_nx;
      if (ld_nxt) nxt <= sel_nxt ? mem_rdata[AW-1:0] : '0;
      if (ld_acc) acc <= sel_acc ? acc + mem_rdata : '0;
      if (is_idle && go) finished <= 1'b0;
      if (is_test && nxt_zero) begin
        finished <= 1'b1;
        total    <= acc;
      end
    end
  end
endmodule

// File: rtl/list_sum_engine_chk.sv
module list_sum_engine_chk #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          go,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rd,
  input logic [DW-1:0] total,
  input logic          finished,
  input logic          is_idle,
  input logic          is_test,
  input logic          nxt_zero
);
  p_start_first_read_r2: assert property (@(posedge clk) disable iff (rst)
    (go && is_idle) |=> (!finished && mem_rd && mem_addr == AW'(1)));

  p_zero_ends_r4: assert property (@(posedge clk) disable iff (rst)
    (is_test && nxt_zero) |=> (finished && is_idle));

  p_nonzero_loops_r4: assert property (@(posedge clk) disable iff (rst)
    (is_test && !nxt_zero) |=> (mem_rd && !finished && !is_idle));

  p_quiet_during_walk_r6: assert property (@(posedge clk) disable iff (rst)
    !is_idle |-> !finished);

  p_result_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (finished && !go) |=> (finished && $stable(total)));

  p_busy_go_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (!is_idle && !is_test) |=> !is_idle);

  p_single_cycle_read_r9: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);
endmodule

bind list_sum_engine list_sum_engine_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .go(go), .mem_addr(mem_addr), .mem_rd(mem_rd),
  .total(total), .finished(finished), .is_idle(is_idle), .is_test(is_test),
  .nxt_zero(nxt_zero)
);

// File: tb/test_list_sum_engine.sv
`timescale 1ns/1ps
module test_list_sum_engine;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic go = 1'b0;
  logic [7:0] mem_addr;
  logic mem_rd;
  logic [15:0] mem_rdata = '0;
  logic [15:0] total;
  logic finished;
  logic [15:0] mem [256];
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  list_sum_engine i_list_sum_engine (
    .clk(clk), .rst(rst), .go(go), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .total(total), .finished(finished)
  );

  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = '0;
  endtask

  task automatic run_walk(input string name, input bit poke_mid);
    logic [15:0] exp_sum = '0;
    logic [7:0]  p = '0;
    int nodes = 0;
    logic [7:0] exp_addr [$];
    bit         exp_rd [$];
    do begin
      exp_rd.push_back(1'b1); exp_addr.push_back(8'(p + 8'd1));
      exp_rd.push_back(1'b0); exp_addr.push_back('0);
      exp_rd.push_back(1'b1); exp_addr.push_back(p);
      exp_rd.push_back(1'b0); exp_addr.push_back('0);
      exp_rd.push_back(1'b0); exp_addr.push_back('0);
      exp_sum = exp_sum + mem[8'(p + 8'd1)];
      p = mem[p][7:0];
      nodes++;
    end while (p != 0 && nodes < 256);

    @(negedge clk) go = 1'b1;
    @(negedge clk) go = 1'b0;
    for (int k = 0; k < 5 * nodes; k++) begin
      if (poke_mid && k == 7) go = 1'b1;
      if (poke_mid && k == 8) go = 1'b0;
      chk(mem_rd == exp_rd[k], $sformatf("R9 %s rd cycle %0d", name, k), mem_rd, exp_rd[k]);
      if (exp_rd[k])
        chk(mem_addr == exp_addr[k], $sformatf("R4 %s addr cycle %0d", name, k), mem_addr, exp_addr[k]);
      chk(finished == 1'b0, $sformatf("R6 %s finished early cycle %0d", name, k), finished, 0);
      @(negedge clk);
    end
    chk(finished == 1'b1, $sformatf("R6 %s finished at 5N", name), finished, 1);
    chk(total == exp_sum, $sformatf("R3 %s total", name), total, exp_sum);
    for (int h = 0; h < 4; h++) begin
      @(negedge clk);
      chk(finished == 1'b1 && total == exp_sum, $sformatf("R7 %s hold %0d", name, h), total, exp_sum);
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    chk(finished == 1'b0, "R1 finished in reset", finished, 0);
    chk(total == 16'h0, "R1 total in reset", total, 0);
    chk(mem_rd == 1'b0, "R1 no read in reset", mem_rd, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(finished == 1'b0, "R1 idle after reset", finished, 0);

    mem[0] = 16'h0000; mem[1] = 16'h1234;
    run_walk("R5 single", 1'b0);

    clear_mem();
    mem[8'h00] = 16'h0040; mem[8'h01] = 16'd5;
    mem[8'h40] = 16'h0013; mem[8'h41] = 16'd100;
    mem[8'h13] = 16'h00C8; mem[8'h14] = 16'd7;
    mem[8'hC8] = 16'h0000; mem[8'hC9] = 16'd9;
    run_walk("R2 chain", 1'b0);
    run_walk("R8 chain poked", 1'b1);

    clear_mem();
    mem[8'h00] = 16'h0030; mem[8'h01] = 16'hFFF0;
    mem[8'h30] = 16'h0080; mem[8'h31] = 16'h0020;
    mem[8'h80] = 16'h0000; mem[8'h81] = 16'h8000;
    run_walk("R3 wrap", 1'b0);
    chk(total == 16'h8010, "R3 wrap literal", total, 16'h8010);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule